// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This controller decides which clocks, oscillators and regulator mode a small processor system keeps during each of its power states. Software asks for one of three low-power states and may ask for low-power regulation in the deepest resumable one. The controller then gates the CPU clock, the core-domain clock, the PLL and the two oscillators. It drives a two-bit regulator mode and a core power-off flag, and it watches only the wakeup sources that count in the state it is in. The always-on timer and watchdog clock enable is never dropped.

Sleep and Stop keep the system's state. Leaving Sleep is immediate. Leaving Stop first turns the crystal oscillator and PLL back on and waits for a synchronised oscillator-ready input before the clocks are released. Standby powers the core domain down, so leaving it runs a core reset sequence and sets a sticky flag that tells software the restart came from Standby. A wakeup source for the requested state that is present in the same cycle as the request cancels the entry. Software-visible values are plain ports: the request inputs, the flag-clear pulse and the flag output.

Top module: `lpm_seq_ctrl`

## Requirements
- R1: After reset the controller is in Run. cpu_clk_en, dom_clk_en, rc_osc_en, xtal_osc_en and pll_en are 1, reg_mode is 2'b00 (main regulation), and core_off, core_rst and sby_flag are 0.
- R2: In Run, req_valid=1 selects the state through req_mode: 2'b01 Sleep, 2'b10 Stop, 2'b11 Standby. The state is entered at the next clock edge. req_mode=2'b00 is ignored.
- R3: In Sleep only cpu_clk_en is 0 and every other enable stays as in Run. irq_any or evt_any returns the controller to Run at the next edge.
- R4: In Stop, cpu_clk_en, dom_clk_en, rc_osc_en, xtal_osc_en and pll_en are 0. reg_mode is 2'b01 if req_reg_lp was 1 with the Stop request, and 2'b00 otherwise.
- R5: Stop is left only when a bit of ext_line, vdet_flag, alarm or bus_wake is 1. irq_any and evt_any have no effect in Stop.
- R6: After Stop the controller enters a settle phase with rc_osc_en, xtal_osc_en and pll_en at 1 and both clocks gated. osc_ready passes through a two-flop synchroniser, and Run is entered on the third edge after osc_ready rises.
- R7: In Standby, reg_mode is 2'b10 (regulator off), core_off is 1, and all clocks, oscillators and the PLL are off.
- R8: Standby is left on ext_rst, wdog_rst, alarm or a rising edge of wake_pin. The exit enters a reset sequence of RST_CYCLES cycles (default 4) with core_rst=1, reg_mode=2'b00 and rc_osc_en=1, and then Run. A wake_pin rise is acted on at the third edge after the pin goes high.
- R9: A wake_pin that is already high when Standby is entered causes no wakeup. The pin must go low and then high again.
- R10: sby_flag becomes 1 when the reset sequence is entered from Standby and stays 1 until clr_sby_flag=1. A set in the same cycle as a clear wins.
- R11: aon_clk_en is 1 in every state.
- R12: In Run, a request is cancelled and the controller stays in Run if a wakeup source for the requested state is present in the same cycle. For Sleep this is irq_any or evt_any. For Stop it is any Stop source. For Standby it is alarm or a wake_pin rise.
- R13: ext_rst or wdog_rst in Run, Sleep, Stop or settle starts the reset sequence and leaves sby_flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Low-power entry request strobe |
| req_mode | input | 2 | Requested state: 01 Sleep, 10 Stop, 11 Standby |
| req_reg_lp | input | 1 | Low-power regulation in Stop |
| clr_sby_flag | input | 1 | Clears the standby-exit flag |
| irq_any | input | 1 | Any pending interrupt |
| evt_any | input | 1 | Any pending event |
| ext_line | input | EXT_LINES | External wake lines |
| vdet_flag | input | 1 | Supply voltage detector output |
| alarm | input | 1 | Always-on timer alarm |
| bus_wake | input | 1 | Bus wakeup indication |
| wake_pin | input | 1 | Asynchronous standby wake pin |
| wdog_rst | input | 1 | Watchdog reset request |
| ext_rst | input | 1 | External reset request |
| osc_ready | input | 1 | Crystal oscillator and PLL ready, asynchronous |
| cpu_clk_en | output | 1 | CPU clock enable |
| dom_clk_en | output | 1 | Core-domain clock enable |
| rc_osc_en | output | 1 | Internal RC oscillator enable |
| xtal_osc_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL enable |
| reg_mode | output | 2 | Regulator: 00 main, 01 low-power, 10 off |
| core_off | output | 1 | Core domain powered down |
| core_rst | output | 1 | Core reset during the post-standby sequence |
| sby_flag | output | 1 | Sticky standby-exit flag |
| aon_clk_en | output | 1 | Always-on watchdog and alarm clock enable |

## Verification
Two things can fall in the same cycle: an entry request and a wakeup source for the state being entered, and the standby-exit flag being set while software clears it. The bench drives req_valid together with irq_any, an ext_line bit or alarm for each of the three states. It also pulses clr_sby_flag in the cycle in which alarm ends Standby. A behavioural model decides on every clock that the request is dropped and that the flag ends at 1, and the outputs are compared against that model.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_SLEEP  = 3'd1,
    ST_STOP   = 3'd2,
    ST_STBY   = 3'd3,
    ST_SETTLE = 3'd4,
    ST_RSTSEQ = 3'd5
  } lpm_state_e;

  localparam logic [1:0] REQ_SLEEP = 2'b01;
  localparam logic [1:0] REQ_STOP  = 2'b10;
  localparam logic [1:0] REQ_STBY  = 2'b11;

  localparam logic [1:0] REG_MAIN = 2'b00;
  localparam logic [1:0] REG_LOWP = 2'b01;
  localparam logic [1:0] REG_OFF  = 2'b10;

  typedef struct packed {
    logic       cpu_clk;
    logic       dom_clk;
    logic       rc_osc;
    logic       xtal_osc;
    logic       pll;
    logic [1:0] reg_mode;
    logic       core_off;
    logic       core_rst;
  } lpm_ctrl_t;

endpackage

// File: rtl/lpm_rst_sync.sv
module lpm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/lpm_wake_edge.sv
module lpm_wake_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  localparam int unsigned MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[MSB-1:0], pin};
      prev_q <= sync_q[MSB];
    end
  end

  assign rise = sync_q[MSB] & ~prev_q;
endmodule

// File: rtl/lpm_settle.sv
module lpm_settle #(
  parameter bit          USE_READY     = 1'b1,
  parameter int unsigned SETTLE_CYCLES = 16,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic ready,
  output logic done
);
  generate
    if (USE_READY) begin : g_ready
      localparam int unsigned MSB = SYNC_STAGES - 1;
      logic [SYNC_STAGES-1:0] rdy_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdy_q <= '0;
        else        rdy_q <= {rdy_q[MSB-1:0], ready};
      end

      assign done = active & rdy_q[MSB];
    end else begin : g_count
      localparam int unsigned CW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
      logic [CW-1:0] cnt_q, cnt_d;

      always_comb begin
        cnt_d = cnt_q;
        if (!active)    cnt_d = '0;
        else if (!done) cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign done = active & (cnt_q == CW'(SETTLE_CYCLES - 1));
    end
  endgenerate
endmodule

// File: rtl/lpm_seq_ctrl.sv
module lpm_seq_ctrl
  import lpm_pkg::*;
#(
  parameter int unsigned EXT_LINES     = 16,
  parameter int unsigned RST_CYCLES    = 4,
  parameter int unsigned SETTLE_CYCLES = 16,
  parameter bit          USE_READY     = 1'b1,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [1:0]           req_mode,
  input  logic                 req_reg_lp,
  input  logic                 clr_sby_flag,
  input  logic                 irq_any,
  input  logic                 evt_any,
  input  logic [EXT_LINES-1:0] ext_line,
  input  logic                 vdet_flag,
  input  logic                 alarm,
  input  logic                 bus_wake,
  input  logic                 wake_pin,
  input  logic                 wdog_rst,
  input  logic                 ext_rst,
  input  logic                 osc_ready,
  output logic                 cpu_clk_en,
  output logic                 dom_clk_en,
  output logic                 rc_osc_en,
  output logic                 xtal_osc_en,
  output logic                 pll_en,
  output logic [1:0]           reg_mode,
  output logic                 core_off,
  output logic                 core_rst,
  output logic                 sby_flag,
  output logic                 aon_clk_en
);
  localparam int unsigned RCW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;

  logic rst_n_s;
  logic wake_rise;
  logic settle_done;

  lpm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_s)
  );

  lpm_wake_edge #(.SYNC_STAGES(SYNC_STAGES)) u_wake_edge (
    .clk  (clk),
    .rst_n(rst_n_s),
    .pin  (wake_pin),
    .rise (wake_rise)
  );

  lpm_state_e state_q, state_d;
  logic       lp_q, lp_d;
  logic       flag_q, flag_d;
  logic       flag_set;
  logic [RCW-1:0] rcnt_q, rcnt_d;

  lpm_settle #(
    .USE_READY    (USE_READY),
    .SETTLE_CYCLES(SETTLE_CYCLES),
    .SYNC_STAGES  (SYNC_STAGES)
  ) u_settle (
    .clk   (clk),
    .rst_n (rst_n_s),
    .active(state_q == ST_SETTLE),
    .ready (osc_ready),
    .done  (settle_done)
  );

  // Wakeup source groups, one per state
  logic reset_src, sleep_wake, stop_wake, stby_wake;
  assign reset_src  = ext_rst | wdog_rst;
  assign sleep_wake = irq_any | evt_any;
  assign stop_wake  = (|ext_line) | vdet_flag | alarm | bus_wake;
  assign stby_wake  = wake_rise | alarm;

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    lp_d     = lp_q;
    rcnt_d   = rcnt_q;
    flag_set = 1'b0;
    if (state_q != ST_RSTSEQ && reset_src) begin
      state_d  = ST_RSTSEQ;
      rcnt_d   = '0;
      flag_set = (state_q == ST_STBY);
    end else begin
      unique case (state_q)
        ST_RUN: begin
          if (req_valid) begin
            unique case (req_mode)
              REQ_SLEEP: if (!sleep_wake) state_d = ST_SLEEP;
              REQ_STOP: begin
                if (!stop_wake) begin
                  state_d = ST_STOP;
                  lp_d    = req_reg_lp;
                end
              end
              REQ_STBY: if (!stby_wake) state_d = ST_STBY;
              default: ;
            endcase
          end
        end
        ST_SLEEP:  if (sleep_wake)  state_d = ST_RUN;
        ST_STOP:   if (stop_wake)   state_d = ST_SETTLE;
        ST_SETTLE: if (settle_done) state_d = ST_RUN;
        ST_STBY: begin
          if (stby_wake) begin
            state_d  = ST_RSTSEQ;
            rcnt_d   = '0;
            flag_set = 1'b1;
          end
        end
        ST_RSTSEQ: begin
          if (rcnt_q == RCW'(RST_CYCLES - 1)) state_d = ST_RUN;
          else                                rcnt_d  = rcnt_q + 1'b1;
        end
        default: state_d = ST_RUN;
      endcase
    end
    flag_d = flag_set | (flag_q & ~clr_sby_flag);
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_RUN;
      lp_q    <= 1'b0;
      flag_q  <= 1'b0;
      rcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      lp_q    <= lp_d;
      flag_q  <= flag_d;
      rcnt_q  <= rcnt_d;
    end
  end

  // Output decode per state
  lpm_ctrl_t ctrl;
  always_comb begin
    ctrl = '{cpu_clk: 1'b1, dom_clk: 1'b1, rc_osc: 1'b1, xtal_osc: 1'b1,
             pll: 1'b1, reg_mode: REG_MAIN, core_off: 1'b0, core_rst: 1'b0};
    unique case (state_q)
      ST_RUN:   ;
      ST_SLEEP: ctrl.cpu_clk = 1'b0;
      ST_STOP: begin
        ctrl.cpu_clk  = 1'b0;
        ctrl.dom_clk  = 1'b0;
        ctrl.rc_osc   = 1'b0;
        ctrl.xtal_osc = 1'b0;
        ctrl.pll      = 1'b0;
        ctrl.reg_mode = lp_q ? REG_LOWP : REG_MAIN;
      end
      ST_SETTLE: begin
        ctrl.cpu_clk = 1'b0;
        ctrl.dom_clk = 1'b0;
      end
      ST_STBY: begin
        ctrl.cpu_clk  = 1'b0;
        ctrl.dom_clk  = 1'b0;
        ctrl.rc_osc   = 1'b0;
        ctrl.xtal_osc = 1'b0;
        ctrl.pll      = 1'b0;
        ctrl.reg_mode = REG_OFF;
        ctrl.core_off = 1'b1;
      end
      ST_RSTSEQ: begin
        ctrl.cpu_clk  = 1'b0;
        ctrl.dom_clk  = 1'b0;
        ctrl.xtal_osc = 1'b0;
        ctrl.pll      = 1'b0;
        ctrl.core_rst = 1'b1;
      end
      default: ;
    endcase
  end

  assign cpu_clk_en  = ctrl.cpu_clk;
  assign dom_clk_en  = ctrl.dom_clk;
  assign rc_osc_en   = ctrl.rc_osc;
  assign xtal_osc_en = ctrl.xtal_osc;
  assign pll_en      = ctrl.pll;
  assign reg_mode    = ctrl.reg_mode;
  assign core_off    = ctrl.core_off;
  assign core_rst    = ctrl.core_rst;
  assign sby_flag    = flag_q;
  assign aon_clk_en  = 1'b1;
endmodule

// File: rtl/lpm_seq_chk.sv
module lpm_seq_chk #(
  parameter int unsigned EXT_LINES = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 irq_any,
  input logic                 evt_any,
  input logic [EXT_LINES-1:0] ext_line,
  input logic                 vdet_flag,
  input logic                 alarm,
  input logic                 bus_wake,
  input logic                 wdog_rst,
  input logic                 ext_rst,
  input logic                 cpu_clk_en,
  input logic                 dom_clk_en,
  input logic                 rc_osc_en,
  input logic                 xtal_osc_en,
  input logic                 pll_en,
  input logic [1:0]           reg_mode,
  input logic                 core_off,
  input logic                 core_rst,
  input logic                 sby_flag
);
  logic in_sleep, in_stop, no_rst;
  assign in_sleep = !cpu_clk_en && dom_clk_en && !core_rst;
  assign in_stop  = !dom_clk_en && !pll_en && !core_off && !core_rst;
  assign no_rst   = !ext_rst && !wdog_rst;

  AST_SLEEP_WAKE_RESUMES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sleep && (irq_any || evt_any) && no_rst) |=> cpu_clk_en); // R3

  AST_STOP_REG_NOT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    in_stop |-> (reg_mode != 2'b10 && !rc_osc_en && !xtal_osc_en)); // R4

  AST_STOP_WAKE_SETTLES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop && ((|ext_line) || vdet_flag || alarm || bus_wake) && no_rst)
      |=> (pll_en && xtal_osc_en && !cpu_clk_en)); // R5

  AST_CPU_NEEDS_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en |-> (dom_clk_en && pll_en && xtal_osc_en)); // R6

  AST_STBY_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    core_off |-> (reg_mode == 2'b10 && !rc_osc_en && !xtal_osc_en && !pll_en && !dom_clk_en)); // R7

  AST_RSTSEQ_MAIN_REG: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> (reg_mode == 2'b00 && !cpu_clk_en && !core_off && rc_osc_en)); // R8

  AST_FLAG_WITH_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sby_flag) |-> core_rst); // R10
endmodule

bind lpm_seq_ctrl lpm_seq_chk #(.EXT_LINES(EXT_LINES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_any    (irq_any),
  .evt_any    (evt_any),
  .ext_line   (ext_line),
  .vdet_flag  (vdet_flag),
  .alarm      (alarm),
  .bus_wake   (bus_wake),
  .wdog_rst   (wdog_rst),
  .ext_rst    (ext_rst),
  .cpu_clk_en (cpu_clk_en),
  .dom_clk_en (dom_clk_en),
  .rc_osc_en  (rc_osc_en),
  .xtal_osc_en(xtal_osc_en),
  .pll_en     (pll_en),
  .reg_mode   (reg_mode),
  .core_off   (core_off),
  .core_rst   (core_rst),
  .sby_flag   (sby_flag)
);

// File: tb/lpm_seq_ctrl_tb.sv
module lpm_seq_ctrl_tb;
  localparam int RSTC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_reg_lp = 0, clr_sby_flag = 0;
  logic [1:0] req_mode = 2'b00;
  logic irq_any = 0, evt_any = 0, vdet_flag = 0, alarm = 0, bus_wake = 0;
  logic wake_pin = 0, wdog_rst = 0, ext_rst = 0, osc_ready = 0;
  logic [15:0] ext_line = '0;
  logic cpu_clk_en, dom_clk_en, rc_osc_en, xtal_osc_en, pll_en;
  logic [1:0] reg_mode;
  logic core_off, core_rst, sby_flag, aon_clk_en;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit checking = 0, finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  lpm_seq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_reg_lp(req_reg_lp), .clr_sby_flag(clr_sby_flag), .irq_any(irq_any),
    .evt_any(evt_any), .ext_line(ext_line), .vdet_flag(vdet_flag), .alarm(alarm),
    .bus_wake(bus_wake), .wake_pin(wake_pin), .wdog_rst(wdog_rst), .ext_rst(ext_rst),
    .osc_ready(osc_ready), .cpu_clk_en(cpu_clk_en), .dom_clk_en(dom_clk_en),
    .rc_osc_en(rc_osc_en), .xtal_osc_en(xtal_osc_en), .pll_en(pll_en),
    .reg_mode(reg_mode), .core_off(core_off), .core_rst(core_rst),
    .sby_flag(sby_flag), .aon_clk_en(aon_clk_en)
  );

  // Behavioural reference: 0 run 1 sleep 2 stop 3 standby 4 settle 5 reset sequence
  int m_st = 0, m_cnt = 0;
  bit m_lp = 0, m_flag = 0;
  bit p1 = 0, p2 = 0, p3 = 0, r1 = 0, r2 = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_lp = 0; m_flag = 0;
      p1 = 0; p2 = 0; p3 = 0; r1 = 0; r2 = 0;
    end else begin
      bit rise, stopw, setf;
      rise  = p2 && !p3;
      stopw = (ext_line != 0) || vdet_flag || alarm || bus_wake;
      setf  = 0;
      if (m_st != 5 && (ext_rst || wdog_rst)) begin
        if (m_st == 3) setf = 1;
        m_st = 5; m_cnt = 0;
      end else begin
        case (m_st)
          0: if (req_valid) begin
               if (req_mode == 2'b01 && !(irq_any || evt_any)) m_st = 1;
               else if (req_mode == 2'b10 && !stopw) begin m_st = 2; m_lp = req_reg_lp; end
               else if (req_mode == 2'b11 && !(rise || alarm)) m_st = 3;
             end
          1: if (irq_any || evt_any) m_st = 0;
          2: if (stopw) m_st = 4;
          4: if (r2) m_st = 0;
          3: if (rise || alarm) begin setf = 1; m_st = 5; m_cnt = 0; end
          5: if (m_cnt == RSTC - 1) m_st = 0; else m_cnt++;
          default: m_st = 0;
        endcase
      end
      m_flag = setf || (m_flag && !clr_sby_flag);
      p3 = p2; p2 = p1; p1 = wake_pin;
      r2 = r1; r1 = osc_ready;
    end
  end

  function automatic logic [10:0] expect_vec();
    logic [10:0] v;
    case (m_st)
      0: v = {5'b11111, 2'b00, 2'b00};
      1: v = {5'b01111, 2'b00, 2'b00};
      2: v = {5'b00000, (m_lp ? 2'b01 : 2'b00), 2'b00};
      3: v = {5'b00000, 2'b10, 2'b10};
      4: v = {5'b00111, 2'b00, 2'b00};
      default: v = {5'b00100, 2'b00, 2'b01};
    endcase
    return {v, m_flag, 1'b1};
  endfunction

  function automatic string tag_of(int s);
    case (s)
      0: return "R1 R2 R11 R12";
      1: return "R3 R11";
      2: return "R4 R5 R11";
      3: return "R7 R9 R11";
      4: return "R6 R11";
      default: return "R8 R10 R13";
    endcase
  endfunction

  always @(negedge clk) begin
    if (checking && !finished) begin
      logic [12:0] act, exp_v;
      act = {cpu_clk_en, dom_clk_en, rc_osc_en, xtal_osc_en, pll_en, reg_mode,
             core_off, core_rst, sby_flag, aon_clk_en};
      exp_v = expect_vec();
      n_chk++;
      if (act !== exp_v) begin
        n_fail++;
        $display("FAIL %s cycle %0d: actual %b expected %b", tag_of(m_st), cyc, act, exp_v);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic request(logic [1:0] mode, logic lp);
    @(negedge clk);
    req_valid = 1; req_mode = mode; req_reg_lp = lp;
    @(negedge clk);
    req_valid = 0; req_mode = 2'b00; req_reg_lp = 0;
  endtask

  task automatic settle_out();
    wait_n(3);
    osc_ready = 1;
    wait_n(5);
    osc_ready = 0;
    wait_n(3);
  endtask

  initial begin
    wait_n(2);
    checking = 1;                 // R1: reset state compared while held
    wait_n(3);
    rst_n = 1;
    wait_n(4);

    // R3: sleep, leave by interrupt then by event
    request(2'b01, 0); wait_n(3);
    irq_any = 1; @(negedge clk); irq_any = 0; wait_n(2);
    request(2'b01, 0); wait_n(2);
    evt_any = 1; @(negedge clk); evt_any = 0; wait_n(2);

    // R2: mode 00 ignored
    request(2'b00, 1); wait_n(3);

    // R4 R5 R6: stop with low-power regulation, irq ignored, line 7 wakes
    request(2'b10, 1); wait_n(3);
    irq_any = 1; evt_any = 1; @(negedge clk); irq_any = 0; evt_any = 0; wait_n(2);
    ext_line = 16'h0080; @(negedge clk); ext_line = '0;
    settle_out();

    // R5: each remaining stop source, main regulation
    for (int k = 0; k < 3; k++) begin
      request(2'b10, 0); wait_n(2);
      if (k == 0) vdet_flag = 1; else if (k == 1) alarm = 1; else bus_wake = 1;
      @(negedge clk);
      vdet_flag = 0; alarm = 0; bus_wake = 0;
      settle_out();
    end

    // R9: pin high before entry; R8: fresh rise wakes
    wake_pin = 1; wait_n(5);
    request(2'b11, 0); wait_n(6);
    wake_pin = 0; wait_n(4);
    wake_pin = 1; wait_n(10);
    wake_pin = 0; wait_n(2);
    // R10: clear
    clr_sby_flag = 1; @(negedge clk); clr_sby_flag = 0; wait_n(2);

    // R10: alarm exit with clear in the same cycle, set wins
    request(2'b11, 0); wait_n(3);
    alarm = 1; clr_sby_flag = 1; @(negedge clk); alarm = 0; clr_sby_flag = 0;
    wait_n(8);
    clr_sby_flag = 1; @(negedge clk); clr_sby_flag = 0; wait_n(2);

    // R8: watchdog and external reset exits from standby
    request(2'b11, 0); wait_n(3);
    wdog_rst = 1; @(negedge clk); wdog_rst = 0; wait_n(7);
    request(2'b11, 0); wait_n(3);
    ext_rst = 1; @(negedge clk); ext_rst = 0; wait_n(7);

    // R12: aborted entries
    @(negedge clk); req_valid = 1; req_mode = 2'b01; irq_any = 1;
    @(negedge clk); req_valid = 0; irq_any = 0; wait_n(3);
    @(negedge clk); req_valid = 1; req_mode = 2'b10; ext_line = 16'h0001;
    @(negedge clk); req_valid = 0; ext_line = '0; wait_n(3);
    @(negedge clk); req_valid = 1; req_mode = 2'b11; alarm = 1;
    @(negedge clk); req_valid = 0; alarm = 0; req_mode = 2'b00; wait_n(3);

    // R13: resets outside standby leave the flag alone
    clr_sby_flag = 1; @(negedge clk); clr_sby_flag = 0; wait_n(2);
    wdog_rst = 1; @(negedge clk); wdog_rst = 0; wait_n(7);
    request(2'b10, 1); wait_n(2);
    ext_rst = 1; @(negedge clk); ext_rst = 0; wait_n(7);
    request(2'b01, 0); wait_n(2);
    ext_rst = 1; @(negedge clk); ext_rst = 0; wait_n(7);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule